// File: doc/BRIEF.md
# PWM Compare Trigger Generator

This block runs an up-counting PWM time base and turns compare matches into two trigger pulses for downstream logic such as converter sampling. The counter starts at a programmable start value and climbs one step per prescaled tick until it reaches the period-end value, which is compare slot 1. It then reloads the start value. Six compare slots are checked against the counter. Matches on the even slots (0, 2, 4) drive trigger 0, and matches on the odd slots (1, 3, 5) drive trigger 1. Each slot has its own enable.

Each trigger output can instead carry an already-generated PWM waveform, which is supplied on an input. Compare reporting can run in one of two modes. In the first, matches are reported in every period. In the second, matches are reported only in the period that ends at a taken reload opportunity, and such an opportunity is taken once every N+1 periods.

Top module: `pwm_cmp_trig`

## Requirements
- R1: While `rst_n` is low, `cnt_o` is 0 and both compare-sourced triggers are low. The counter is idle, and the first tick after reset loads `init_val` into the counter.
- R2: On each tick, the running counter increments by one. On a tick where the counter is equal to or above the period end (compare slot 1, bits [2*CNT_W-1:CNT_W] of `cmp_vals`), it reloads `init_val` instead.
- R3: A tick occurs on every 2^`pre_sel`-th clock in which `cnt_en` is high. With `pre_sel` = 0, a tick occurs on every enabled clock.
- R4: While `cnt_en` is low, neither the counter nor the prescaler advances.
- R5: Compare slot i occupies bits [i*CNT_W +: CNT_W] of `cmp_vals` and is enabled by `cmp_en[i]`. Matches on the even slots are ORed onto `trig0_o`, and matches on the odd slots are ORed onto `trig1_o`.
- R6: A compare trigger is a pulse one clock long. It appears in the first clock cycle in which the counter holds the matching value, even when the prescaler holds that value for several clocks.
- R7: When `trig_src_sel[k]` is 1, trigger k follows `pwm_in[k]` combinationally. When it is 0, trigger k carries the compare trigger.
- R8: When `rld_mode` = 0, matches are reported in every period. When `rld_mode` = 1, matches are reported only in every (`rld_freq`+1)-th period, counted from the first load of `init_val`. In this mode the first `rld_freq` periods are silent.
- R9: When `rld_mode` = 1 and `rld_freq` = 0, the block behaves exactly as it does with `rld_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| pre_sel | input | PRE_W | Prescaler exponent; divide by 2^pre_sel |
| init_val | input | CNT_W | Counter start value |
| cmp_vals | input | NUM_CMP*CNT_W | Compare slots, packed, slot 1 is the period end |
| cmp_en | input | NUM_CMP | Per-slot trigger enable |
| trig_src_sel | input | 2 | Per-trigger source: 0 compare, 1 PWM input |
| pwm_in | input | 2 | Final PWM signals for pass-through |
| rld_mode | input | 1 | 0 every period, 1 reload-opportunity only |
| rld_freq | input | RLD_W | Reload interval N; opportunity every N+1 periods |
| cnt_o | output | CNT_W | Counter value |
| trig0_o | output | 1 | Trigger 0 |
| trig1_o | output | 1 | Trigger 1 |

## Verification
The bench uses the default parameters: a 16-bit counter, a 3-bit prescaler exponent, a 4-bit reload interval and six slots. With these values, the largest reload interval of sixteen periods fits into short periods of four counts. Prescaler ratios of 1 and 4, gapped count enables, adjacent and simultaneous slot matches, a lowered period end and mixed trigger sources are all compared cycle by cycle against a model written from the requirements.

// File: rtl/pwmtrig_pkg.sv
package pwmtrig_pkg;
  typedef enum logic {
    RLD_EVERY  = 1'b0,
    RLD_SPARSE = 1'b1
  } rld_mode_e;

  localparam int unsigned NUM_TRIG = 2;
endpackage

// File: rtl/pwmtrig_prescale.sv
module pwmtrig_prescale #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(pre_sel));
    end
  end

  always_comb begin
    tick_o = cnt_en && ((div_q & mask) == mask);
    div_d  = cnt_en ? div_q + 1'b1 : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwmtrig_counter.sv
module pwmtrig_counter
  import pwmtrig_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] end_val,
  input  rld_mode_e        rld_mode,
  input  logic [RLD_W-1:0] rld_freq,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fresh_o,
  output logic             win_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fresh_q, fresh_d;
  logic [RLD_W-1:0] per_q, per_d;
  logic             at_end;

  always_comb begin
    at_end  = (cnt_q >= end_val);
    run_d   = run_q;
    cnt_d   = cnt_q;
    per_d   = per_q;
    fresh_d = 1'b0;
    if (tick) begin
      fresh_d = 1'b1;
      if (!run_q) begin
        run_d = 1'b1;
        cnt_d = init_val;
        per_d = '0;
      end else if (at_end) begin
        cnt_d = init_val;
        per_d = (per_q >= rld_freq) ? '0 : per_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      fresh_q <= 1'b0;
      per_q   <= '0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      fresh_q <= fresh_d;
      per_q   <= per_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign fresh_o = fresh_q;
  assign win_o   = (rld_mode == RLD_EVERY) || (per_q == rld_freq);
endmodule

// File: rtl/pwmtrig_match.sv
module pwmtrig_match
  import pwmtrig_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 6
) (
  input  logic [CNT_W-1:0]         cnt,
  input  logic                     fresh,
  input  logic                     win,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic [NUM_CMP-1:0]       cmp_en,
  input  logic [NUM_TRIG-1:0]      src_sel,
  input  logic [NUM_TRIG-1:0]      pwm_in,
  output logic [NUM_TRIG-1:0]      trig
);
  logic [NUM_CMP-1:0]  hit;
  logic [NUM_TRIG-1:0] cmp_or;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
    assign hit[g] = fresh && win && cmp_en[g] &&
                    (cnt == cmp_vals[g*CNT_W +: CNT_W]);
  end

  always_comb begin
    cmp_or = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      cmp_or[i % NUM_TRIG] = cmp_or[i % NUM_TRIG] | hit[i];
    end
  end

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_out
    assign trig[k] = src_sel[k] ? pwm_in[k] : cmp_or[k];
  end
endmodule

// File: rtl/pwm_cmp_trig.sv
module pwm_cmp_trig
  import pwmtrig_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_W   = 3,
  parameter int unsigned RLD_W   = 4,
  parameter int unsigned NUM_CMP = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_en,
  input  logic [PRE_W-1:0]         pre_sel,
  input  logic [CNT_W-1:0]         init_val,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic [NUM_CMP-1:0]       cmp_en,
  input  logic [1:0]               trig_src_sel,
  input  logic [1:0]               pwm_in,
  input  logic                     rld_mode,
  input  logic [RLD_W-1:0]         rld_freq,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     trig0_o,
  output logic                     trig1_o
);
  localparam int unsigned END_SLOT = 1;

  logic             tick;
  logic             fresh;
  logic             rld_win;
  logic [1:0]       trig;
  logic [CNT_W-1:0] end_val;

  assign end_val = cmp_vals[END_SLOT*CNT_W +: CNT_W];

  pwmtrig_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .pre_sel (pre_sel),
    .tick_o  (tick)
  );

  pwmtrig_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .init_val (init_val),
    .end_val  (end_val),
    .rld_mode (rld_mode_e'(rld_mode)),
    .rld_freq (rld_freq),
    .cnt_o    (cnt_o),
    .fresh_o  (fresh),
    .win_o    (rld_win)
  );

  pwmtrig_match #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_match (
    .cnt      (cnt_o),
    .fresh    (fresh),
    .win      (rld_win),
    .cmp_vals (cmp_vals),
    .cmp_en   (cmp_en),
    .src_sel  (trig_src_sel),
    .pwm_in   (pwm_in),
    .trig     (trig)
  );

  assign trig0_o = trig[0];
  assign trig1_o = trig[1];
endmodule

// File: rtl/pwm_cmp_trig_chk.sv
module pwm_cmp_trig_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_en,
  input logic [CNT_W-1:0]   init_val,
  input logic [NUM_CMP-1:0] cmp_en,
  input logic [1:0]         trig_src_sel,
  input logic               rld_mode,
  input logic [CNT_W-1:0]   cnt_o,
  input logic               trig0_o,
  input logic               trig1_o,
  input logic               win
);
  function automatic logic [NUM_CMP-1:0] parity_mask(input int par);
    logic [NUM_CMP-1:0] m;
    for (int i = 0; i < NUM_CMP; i++) m[i] = ((i % 2) == par);
    return m;
  endfunction

  localparam logic [NUM_CMP-1:0] EVEN_M = parity_mask(0);
  localparam logic [NUM_CMP-1:0] ODD_M  = parity_mask(1);

  // R4
  freeze_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_en) |-> $stable(cnt_o));

  // R2
  step_or_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o != $past(cnt_o)) |->
      (cnt_o == CNT_W'($past(cnt_o) + 1'b1) || cnt_o == init_val));

  // R5
  even_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_src_sel[0] && trig0_o) |-> ((cmp_en & EVEN_M) != '0));

  // R5
  odd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_src_sel[1] && trig1_o) |-> ((cmp_en & ODD_M) != '0));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_src_sel[0] && trig0_o) |=>
      (cnt_o != $past(cnt_o) || trig_src_sel[0] || !trig0_o));

  // R8
  reload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_mode && !trig_src_sel[1] && trig1_o) |-> win);
endmodule

bind pwm_cmp_trig pwm_cmp_trig_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en       (cnt_en),
  .init_val     (init_val),
  .cmp_en       (cmp_en),
  .trig_src_sel (trig_src_sel),
  .rld_mode     (rld_mode),
  .cnt_o        (cnt_o),
  .trig0_o      (trig0_o),
  .trig1_o      (trig1_o),
  .win          (rld_win)
);

// File: tb/pwm_cmp_trig_test.sv
module pwm_cmp_trig_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NC = 6;
  localparam int RUN_CYC = 150;
  localparam int N_CFG = 7;

  typedef struct packed {
    logic [15:0] init;
    logic [15:0] v0, v1, v2, v3, v4, v5;
    logic [5:0]  en;
    logic        mode;
    logic [3:0]  nf;
    logic [2:0]  ps;
    logic [1:0]  sel;
    logic        gap;
  } cfg_t;

  // init v0 v1(end) v2 v3 v4 v5 en mode nf ps sel gap
  localparam cfg_t CFG [N_CFG] = '{
    '{16'd0,   16'd3,   16'd9,   16'd5,   16'd7,   16'd9,   16'd2,  6'h3F, 1'b0, 4'd0,  3'd0, 2'b00, 1'b0},
    '{16'd0,   16'd3,   16'd9,   16'd5,   16'd7,   16'd9,   16'd2,  6'h3F, 1'b0, 4'd0,  3'd2, 2'b00, 1'b0},
    '{16'd0,   16'd3,   16'd9,   16'd4,   16'd7,   16'd9,   16'd2,  6'h3F, 1'b1, 4'd2,  3'd0, 2'b00, 1'b0},
    '{16'd100, 16'd100, 16'd110, 16'd101, 16'd105, 16'd110, 16'd50, 6'h2B, 1'b1, 4'd0,  3'd0, 2'b00, 1'b0},
    '{16'd0,   16'd1,   16'd3,   16'd3,   16'd2,   16'd0,   16'd0,  6'h3F, 1'b1, 4'd15, 3'd0, 2'b00, 1'b0},
    '{16'd4,   16'd5,   16'd12,  16'd8,   16'd6,   16'd12,  16'd9,  6'h3F, 1'b0, 4'd0,  3'd1, 2'b00, 1'b1},
    '{16'd0,   16'd2,   16'd6,   16'd4,   16'd3,   16'd6,   16'd1,  6'h3F, 1'b0, 4'd0,  3'd0, 2'b01, 1'b0}
  };

  logic           clk, rst_n, cnt_en, rld_mode;
  logic [2:0]     pre_sel;
  logic [CW-1:0]  init_val;
  logic [NC*CW-1:0] cmp_vals;
  logic [NC-1:0]  cmp_en;
  logic [1:0]     trig_src_sel, pwm_in;
  logic [3:0]     rld_freq;
  logic [CW-1:0]  cnt_o;
  logic           trig0_o, trig1_o;

  int n_chk, n_bad;
  bit done;

  pwm_cmp_trig uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pre_sel(pre_sel),
    .init_val(init_val), .cmp_vals(cmp_vals), .cmp_en(cmp_en),
    .trig_src_sel(trig_src_sel), .pwm_in(pwm_in), .rld_mode(rld_mode),
    .rld_freq(rld_freq), .cnt_o(cnt_o), .trig0_o(trig0_o), .trig1_o(trig1_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model written from the requirements
  bit m_run, m_fresh;
  int m_cnt, m_pre, m_per;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_fresh = 0; m_cnt = 0; m_pre = 0; m_per = 0;
    end else begin
      int msk;
      bit tk;
      msk = (1 << pre_sel) - 1;
      tk = cnt_en && ((m_pre & msk) == msk);
      if (cnt_en) m_pre = (m_pre + 1) % 128;
      m_fresh = tk;
      if (tk) begin
        if (!m_run) begin
          m_run = 1; m_cnt = int'(init_val); m_per = 0;
        end else if (m_cnt >= int'(cmp_vals[CW +: CW])) begin
          m_cnt = int'(init_val);
          m_per = (m_per >= int'(rld_freq)) ? 0 : m_per + 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  function automatic bit exp_trig(int k);
    bit acc, win;
    if (trig_src_sel[k]) return pwm_in[k];
    win = !rld_mode || (m_per == int'(rld_freq));
    acc = 0;
    for (int i = k; i < NC; i += 2)
      if (m_fresh && win && cmp_en[i] && m_cnt == int'(cmp_vals[i*CW +: CW])) acc = 1;
    return acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic string trig_tag(int idx);
    case (idx)
      0: return "R5";
      1: return "R6";
      2: return "R8";
      3: return "R9";
      4: return "R8";
      5: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic string cnt_tag(int idx);
    case (idx)
      1: return "R3";
      5: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic apply(cfg_t c);
    init_val = c.init;
    cmp_vals = {c.v5, c.v4, c.v3, c.v2, c.v1, c.v0};
    cmp_en = c.en; rld_mode = c.mode; rld_freq = c.nf;
    pre_sel = c.ps; trig_src_sel = c.sel;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic compare_all(string ct, string tt);
    check(ct, int'(cnt_o), m_cnt);
    check(tt, int'(trig0_o), int'(exp_trig(0)));
    check(tt, int'(trig1_o), int'(exp_trig(1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; cnt_en = 1'b0; pwm_in = 2'b00;
    apply(CFG[0]);
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", int'(cnt_o), 0);
    check("R1", int'(trig0_o), 0);
    check("R1", int'(trig1_o), 0);
    rst_n = 1'b1;

    for (int e = 0; e < N_CFG; e++) begin
      apply(CFG[e]);
      do_reset();
      for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
        cnt_en = CFG[e].gap ? ((cyc % 3) != 2) : 1'b1;
        pwm_in = 2'(cyc >> 1);
        #1;
        compare_all(cnt_tag(e), trig_tag(e));
        @(negedge clk);
      end
    end

    // R1: first tick after reset loads init_val
    apply(CFG[3]);
    do_reset();
    cnt_en = 1'b1;
    @(negedge clk);
    check("R1", int'(cnt_o), 100);

    // R4: hold count enable low, counter frozen
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    begin
      int held;
      held = int'(cnt_o);
      repeat (6) begin
        @(negedge clk);
        check("R4", int'(cnt_o), held);
        check("R4", int'(trig0_o), 0);
      end
    end

    // R2: lowering the period end below the count forces a reload
    apply(CFG[0]);
    cmp_vals[CW +: CW] = 16'd30;
    do_reset();
    cnt_en = 1'b1;
    repeat (12) @(negedge clk);
    check("R2", int'(cnt_o), 11);
    cmp_vals[CW +: CW] = 16'd5;
    @(negedge clk);
    check("R2", int'(cnt_o), 0);

    // R7: both triggers follow the PWM inputs
    trig_src_sel = 2'b11;
    pwm_in = 2'b10; #1;
    check("R7", int'(trig0_o), 0);
    check("R7", int'(trig1_o), 1);
    pwm_in = 2'b01; #1;
    check("R7", int'(trig0_o), 1);
    check("R7", int'(trig1_o), 0);

    summary();
  end
endmodule